// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the device side of a receive path that hands incoming frames to host memory through a circular list of descriptors. The host prepares each descriptor by giving the device ownership, a buffer address and a buffer size; the block takes one frame at a time from a byte stream, checks that the current descriptor belongs to the device, copies the bytes into the buffer and then writes a completed status word back to the descriptor, handing ownership back to the host.

The status word that comes back carries the length of the frame as received (trailing 4-byte CRC included), a set of individual error flags and a summary error bit. When the host has not yet returned the current descriptor, the frame is discarded whole and a counter of missed frames advances. The walk through the ring restarts at index 0 after a descriptor marked as the ring's end, or after the last index the ring can hold.

Descriptor reads use a port with one cycle of latency. Descriptor writes and buffer byte writes complete in the cycle they are issued. No port applies backpressure toward the block.

Top module: `rx_ring_writer`

## Requirements
- R1: On the first byte of a frame the block reads the descriptor at its current ring index; the descriptor belongs to the device when status bit 31 is 1, and its buffer size is status bits 12:0 (1536 when the host uses the default buffer).
- R2: Byte k of an accepted frame (counting from 0) is written to the descriptor's buffer address plus k, in arrival order, one byte per accepted input beat.
- R3: On writeback, status bit 31 is 0 and bits 12:0 hold the number of bytes received including the 4 CRC bytes, saturating at 8191.
- R4: A frame flagged with in_crc_err on its last byte gets status bit 19 set; status bit 21 is set exactly when any of bits 19, 20 or 22 is set.
- R5: A frame longer than the buffer size has only its first size bytes written; its writeback sets bit 22 and bit 21 and still reports the full received length.
- R6: A frame shorter than 64 bytes (CRC included) is written back with bit 20 and bit 21 set.
- R7: When the current descriptor has status bit 31 equal to 0, the frame is consumed without any buffer or descriptor write, missed_cnt rises by 1 at its last byte, and the ring index does not move.
- R8: After a writeback the index moves to the next descriptor, or to 0 when the descriptor had bit 30 (end of ring) set or was at index RING_SIZE-1; bit 30 is kept in the written-back status.
- R9: rx_ok pulses for one cycle together with an error-free writeback, rx_err with a writeback that has bit 21 set; never both.
- R10: After reset, in_ready, all write enables, both pulses and missed_cnt are 0 and the ring index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte present on the input stream |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_crc_err | input | 1 | CRC failure, sampled with the final byte |
| in_ready | output | 1 | Block takes the byte this cycle |
| dsc_rd_en | output | 1 | Descriptor read request |
| dsc_rd_idx | output | IDX_W | Index of the descriptor read |
| dsc_rd_status | input | 32 | Status word, one cycle after the request |
| dsc_rd_addr | input | ADDR_W | Buffer address, one cycle after the request |
| dsc_wr_en | output | 1 | Status writeback strobe |
| dsc_wr_idx | output | IDX_W | Index written back |
| dsc_wr_status | output | 32 | Completed status word |
| buf_wr_en | output | 1 | Buffer byte write strobe |
| buf_wr_addr | output | ADDR_W | Byte address in host memory |
| buf_wr_data | output | 8 | Byte written |
| rx_ok | output | 1 | Good frame completed |
| rx_err | output | 1 | Errored frame completed |
| missed_cnt | output | MISS_W | Frames dropped for lack of a descriptor |

## Verification
A ring index that drifts shows up at the first writeback after it, as a wrong dsc_wr_idx and a buffer address in the wrong region, within one frame. A wrong byte count is visible on the very next buffer write address and later in bits 12:0 of the status and in the truncation point. A stuck flag register shows on the next frame's status and on the choice between rx_ok and rx_err in the same cycle as the writeback, while a lost ownership decision shows as buffer writes for a dropped frame or a missed_cnt that fails to move at that frame's last byte.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    localparam int STS_W       = 32;
    localparam int LEN_W       = 13;
    localparam int OWN_POS     = 31;
    localparam int EOR_POS     = 30;
    localparam int LONG_POS    = 22;
    localparam int SUM_POS     = 21;
    localparam int RUNT_POS    = 20;
    localparam int CRC_POS     = 19;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_STREAM,
        ST_DROP,
        ST_WB
    } rxr_state_e;

    typedef struct packed {
        logic too_long;
        logic runt;
        logic crc;
    } rxr_flags_t;

    function automatic logic any_err(rxr_flags_t f);
        return f.too_long | f.runt | f.crc;
    endfunction

    function automatic logic [STS_W-1:0] pack_status(logic eor, rxr_flags_t f,
                                                     logic [LEN_W-1:0] len);
        logic [STS_W-1:0] s;
        s            = '0;
        s[LEN_W-1:0] = len;
        s[CRC_POS]   = f.crc;
        s[RUNT_POS]  = f.runt;
        s[LONG_POS]  = f.too_long;
        s[SUM_POS]   = any_err(f);
        s[EOR_POS]   = eor;
        s[OWN_POS]   = 1'b0;
        return s;
    endfunction

endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
    parameter int RING_SIZE = 4,
    localparam int IDX_W    = (RING_SIZE > 1) ? $clog2(RING_SIZE) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  logic             eor,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RING_SIZE - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (advance) begin
            if (eor || idx == LAST_IDX) idx <= '0;
            else                        idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/rxr_frame_track.sv
module rxr_frame_track
    import rxr_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int RUNT_MIN = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  size,
    input  logic              byte_acc,
    input  logic              byte_last,
    input  logic              crc_in,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [LEN_W-1:0]  len,
    output rxr_flags_t        flags
);
    localparam logic [LEN_W-1:0] LEN_MAX  = '1;
    localparam logic [LEN_W-1:0] RUNT_LIM = LEN_W'(RUNT_MIN);

    logic [ADDR_W-1:0] base_q;
    logic [LEN_W-1:0]  size_q;
    logic [LEN_W-1:0]  count_q;
    logic              crc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            size_q  <= '0;
            count_q <= '0;
            crc_q   <= 1'b0;
        end else if (start) begin
            base_q  <= base;
            size_q  <= size;
            count_q <= '0;
            crc_q   <= 1'b0;
        end else if (byte_acc) begin
            if (count_q != LEN_MAX) count_q <= count_q + 1'b1;
            if (byte_last)          crc_q   <= crc_in;
        end
    end

    assign wr_en          = byte_acc && (count_q < size_q);
    assign wr_addr        = base_q + ADDR_W'(count_q);
    assign len            = count_q;
    assign flags.too_long = count_q > size_q;
    assign flags.runt     = count_q < RUNT_LIM;
    assign flags.crc      = crc_q;
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int RING_SIZE = 4,
    parameter int ADDR_W    = 32,
    parameter int MISS_W    = 16,
    parameter int RUNT_MIN  = 64,
    localparam int IDX_W    = (RING_SIZE > 1) ? $clog2(RING_SIZE) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    input  logic              in_crc_err,
    output logic              in_ready,
    output logic              dsc_rd_en,
    output logic [IDX_W-1:0]  dsc_rd_idx,
    input  logic [31:0]       dsc_rd_status,
    input  logic [ADDR_W-1:0] dsc_rd_addr,
    output logic              dsc_wr_en,
    output logic [IDX_W-1:0]  dsc_wr_idx,
    output logic [31:0]       dsc_wr_status,
    output logic              buf_wr_en,
    output logic [ADDR_W-1:0] buf_wr_addr,
    output logic [7:0]        buf_wr_data,
    output logic              rx_ok,
    output logic              rx_err,
    output logic [MISS_W-1:0] missed_cnt
);
    rxr_state_e        state_q, state_d;
    logic [IDX_W-1:0]  idx;
    logic              eor_q;
    logic              owned;
    logic              byte_acc;
    logic              frame_end;
    logic [LEN_W-1:0]  len;
    rxr_flags_t        flags;
    logic              unused_sts;

    assign owned      = dsc_rd_status[OWN_POS];
    assign unused_sts = ^dsc_rd_status[29:LEN_W];
    assign frame_end  = in_valid && in_last;
    assign byte_acc   = in_valid && (state_q == ST_STREAM);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (in_valid)  state_d = ST_FETCH;
            ST_FETCH:  state_d = owned ? ST_STREAM : ST_DROP;
            ST_STREAM: if (frame_end) state_d = ST_WB;
            ST_DROP:   if (frame_end) state_d = ST_IDLE;
            ST_WB:     state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            eor_q      <= 1'b0;
            missed_cnt <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FETCH) eor_q <= dsc_rd_status[EOR_POS];
            if (state_q == ST_DROP && frame_end) missed_cnt <= missed_cnt + 1'b1;
        end
    end

    rxr_ring_ptr #(.RING_SIZE(RING_SIZE)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .advance (state_q == ST_WB),
        .eor     (eor_q),
        .idx     (idx)
    );

    rxr_frame_track #(.ADDR_W(ADDR_W), .RUNT_MIN(RUNT_MIN)) u_track (
        .clk       (clk),
        .rst       (rst),
        .start     (state_q == ST_FETCH && owned),
        .base      (dsc_rd_addr),
        .size      (dsc_rd_status[LEN_W-1:0]),
        .byte_acc  (byte_acc),
        .byte_last (in_last),
        .crc_in    (in_crc_err),
        .wr_en     (buf_wr_en),
        .wr_addr   (buf_wr_addr),
        .len       (len),
        .flags     (flags)
    );

    assign in_ready      = (state_q == ST_STREAM) || (state_q == ST_DROP);
    assign dsc_rd_en     = (state_q == ST_IDLE) && in_valid;
    assign dsc_rd_idx    = idx;
    assign dsc_wr_en     = (state_q == ST_WB);
    assign dsc_wr_idx    = idx;
    assign dsc_wr_status = pack_status(eor_q, flags, len);
    assign buf_wr_data   = in_data;
    assign rx_ok         = (state_q == ST_WB) && !any_err(flags);
    assign rx_err        = (state_q == ST_WB) && any_err(flags);
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
    parameter int IDX_W  = 2,
    parameter int MISS_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_ready,
    input logic              dsc_wr_en,
    input logic [31:0]       dsc_wr_status,
    input logic              buf_wr_en,
    input logic              rx_ok,
    input logic              rx_err,
    input logic [MISS_W-1:0] missed_cnt
);
    p_own_cleared_r3: assert property (@(posedge clk) disable iff (rst)
        dsc_wr_en |-> !dsc_wr_status[31]);

    p_summary_r4: assert property (@(posedge clk) disable iff (rst)
        dsc_wr_en |-> (dsc_wr_status[21] ==
                       (dsc_wr_status[19] | dsc_wr_status[20] | dsc_wr_status[22])));

    p_pulse_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(rx_ok && rx_err));

    p_pulse_on_wb_r9: assert property (@(posedge clk) disable iff (rst)
        (rx_ok || rx_err) |-> dsc_wr_en);

    p_err_matches_r9: assert property (@(posedge clk) disable iff (rst)
        dsc_wr_en |-> (rx_err == dsc_wr_status[21]));

    p_miss_step_r7: assert property (@(posedge clk) disable iff (rst)
        (missed_cnt != $past(missed_cnt)) |-> (missed_cnt == $past(missed_cnt) + 1'b1));

    p_write_needs_ready_r2: assert property (@(posedge clk) disable iff (rst)
        buf_wr_en |-> in_ready);

    p_no_wb_while_stream_r3: assert property (@(posedge clk) disable iff (rst)
        dsc_wr_en |-> !in_ready);
endmodule

bind rx_ring_writer rx_ring_writer_chk #(.IDX_W(IDX_W), .MISS_W(MISS_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .in_ready      (in_ready),
    .dsc_wr_en     (dsc_wr_en),
    .dsc_wr_status (dsc_wr_status),
    .buf_wr_en     (buf_wr_en),
    .rx_ok         (rx_ok),
    .rx_err        (rx_err),
    .missed_cnt    (missed_cnt)
);

// File: tb/rx_ring_writer_bench.sv
module rx_ring_writer_bench;
    localparam int RING = 4;
    localparam int IW   = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        in_crc_err = 1'b0;
    logic        in_ready;
    logic        dsc_rd_en;
    logic [IW-1:0] dsc_rd_idx;
    logic [31:0] dsc_rd_status;
    logic [31:0] dsc_rd_addr;
    logic        dsc_wr_en;
    logic [IW-1:0] dsc_wr_idx;
    logic [31:0] dsc_wr_status;
    logic        buf_wr_en;
    logic [31:0] buf_wr_addr;
    logic [7:0]  buf_wr_data;
    logic        rx_ok;
    logic        rx_err;
    logic [15:0] missed_cnt;

    always #10 clk = ~clk;

    rx_ring_writer u_rx_ring_writer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_crc_err(in_crc_err), .in_ready(in_ready),
        .dsc_rd_en(dsc_rd_en), .dsc_rd_idx(dsc_rd_idx),
        .dsc_rd_status(dsc_rd_status), .dsc_rd_addr(dsc_rd_addr),
        .dsc_wr_en(dsc_wr_en), .dsc_wr_idx(dsc_wr_idx),
        .dsc_wr_status(dsc_wr_status), .buf_wr_en(buf_wr_en),
        .buf_wr_addr(buf_wr_addr), .buf_wr_data(buf_wr_data),
        .rx_ok(rx_ok), .rx_err(rx_err), .missed_cnt(missed_cnt)
    );

    // host memory model for the descriptor table
    logic [31:0] mem_sts [RING];
    logic [31:0] mem_adr [RING];

    always @(posedge clk) begin
        if (dsc_rd_en) begin
            dsc_rd_status <= mem_sts[dsc_rd_idx];
            dsc_rd_addr   <= mem_adr[dsc_rd_idx];
        end
        if (dsc_wr_en) mem_sts[dsc_wr_idx] <= dsc_wr_status;
    end

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    bit mon_on  = 0;

    int          model_idx  = 0;
    int          model_miss = 0;
    logic [39:0] exp_buf [$];
    logic [39:0] exp_dsc [$];

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor, sampling mid-way between the falling and rising edges
    always begin
        @(negedge clk);
        #5;
        if (mon_on) begin
            if (buf_wr_en) begin
                if (exp_buf.size() == 0)
                    check(0, "R2/R5 unexpected buffer write", {24'd0, buf_wr_addr, buf_wr_data}, 0);
                else begin
                    logic [39:0] e;
                    e = exp_buf.pop_front();
                    check({buf_wr_addr, buf_wr_data} == e, "R2 buffer byte",
                          {24'd0, buf_wr_addr, buf_wr_data}, {24'd0, e});
                end
            end
            if (dsc_wr_en) begin
                if (exp_dsc.size() == 0)
                    check(0, "R7 unexpected writeback", {30'd0, dsc_wr_idx, dsc_wr_status}, 0);
                else begin
                    logic [39:0] e;
                    e = exp_dsc.pop_front();
                    check({6'd0, dsc_wr_idx, dsc_wr_status} == e, "R3/R4/R8 writeback",
                          {30'd0, dsc_wr_idx, dsc_wr_status}, {24'd0, e});
                    check(rx_ok == !e[21] && rx_err == e[21], "R9 completion pulse",
                          {62'd0, rx_ok, rx_err}, {62'd0, !e[21], e[21]});
                end
            end else begin
                check(!rx_ok && !rx_err, "R9 pulse without writeback",
                      {62'd0, rx_ok, rx_err}, 0);
            end
        end
    end

    initial begin
        while (1) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                check(0, "watchdog", cycles, 100000);
                $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
                $finish;
            end
        end
    end

    task automatic arm(input int i, input int size);
        mem_sts[i] = 32'h8000_0000 | ((i == RING-1) ? 32'h4000_0000 : 0) | size;
        mem_adr[i] = 32'h1000_0000 + i * 32'h800;
    endtask

    task automatic send(input int len, input bit crc, input logic [7:0] seed);
        logic [31:0] st;
        st = mem_sts[model_idx];
        if (st[31]) begin
            int size;
            logic [31:0] s;
            int rl;
            size = int'(st[12:0]);
            for (int k = 0; k < len; k++)
                if (k < size) exp_buf.push_back({mem_adr[model_idx] + k, 8'(seed + k)});
            rl = (len > 8191) ? 8191 : len;
            s = 32'(rl);
            s[19] = crc;
            s[20] = (rl < 64);
            s[22] = (rl > size);
            s[21] = s[19] | s[20] | s[22];
            s[30] = st[30];
            exp_dsc.push_back({6'd0, 2'(model_idx), s});
            model_idx = (st[30] || model_idx == RING-1) ? 0 : model_idx + 1;
        end else begin
            model_miss++;
        end
        for (int k = 0; k < len; k++) begin
            in_valid   = 1'b1;
            in_data    = 8'(seed + k);
            in_last    = (k == len - 1);
            in_crc_err = (k == len - 1) ? crc : 1'b0;
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0; in_crc_err = 1'b0;
        repeat (4) @(negedge clk);
        check(exp_buf.size() == 0, "R2/R5 buffer writes complete", exp_buf.size(), 0);
        check(exp_dsc.size() == 0, "R3 writeback issued", exp_dsc.size(), 0);
        check(missed_cnt == 16'(model_miss), "R7 missed count", missed_cnt, model_miss);
    endtask

    initial begin
        for (int i = 0; i < RING; i++) arm(i, 1536);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #5;
        check(!in_ready && !dsc_rd_en && !dsc_wr_en && !buf_wr_en, "R10 reset outputs",
              {60'd0, in_ready, dsc_rd_en, dsc_wr_en, buf_wr_en}, 0);
        check(!rx_ok && !rx_err && missed_cnt == 0, "R10 reset pulses/count",
              {46'd0, rx_ok, rx_err, missed_cnt}, 0);
        check(dsc_rd_idx == 0, "R10 reset index", dsc_rd_idx, 0);
        @(negedge clk);
        mon_on = 1;

        send(64, 0, 8'h10);     // R1 R2 R3 good frame, desc 0
        send(70, 1, 8'h40);     // R4 CRC error, desc 1
        send(20, 0, 8'h80);     // R6 runt, desc 2
        send(64, 0, 8'hC0);     // R8 end-of-ring desc 3
        send(30, 0, 8'h22);     // R7 desc 0 still host-owned: dropped
        check(dsc_rd_idx == 0, "R7 index held after drop", dsc_rd_idx, 0);
        for (int i = 0; i < RING; i++) arm(i, 1536);
        arm(1, 100);
        send(64, 0, 8'h01);     // R8 wrap back to desc 0
        send(120, 0, 8'h55);    // R5 truncation at 100 bytes
        send(1536, 0, 8'h07);   // R1 exact buffer fill, no error
        send(1540, 1, 8'h09);   // R5 R4 over-length with CRC error on EOR slot

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule